// File: doc/BRIEF.md
# Nonvolatile Setting Store Sequencer

This block sits between a serial command front end and two 10-bit wiper registers. It owns a small array of sixteen 16-bit nonvolatile words and moves settings between that array and the wipers. Words 0 and 1 hold the saved setting of each channel. Words 2 to 14 are free user words. Word 15 carries a factory tolerance value that cannot be overwritten. The array is modelled as a register file, and every slow operation has a latency counted in clock cycles that is set by a parameter.

The front end presents one decoded command per cycle on `cmd_valid`, `cmd_op`, `cmd_addr` and `cmd_data`. The sequencer accepts the command only when `busy` is low. Saving a word, restoring both channels and reading a stored word are long operations. During each of them `ready` is held low and `busy` holds off the front end. Restoring one channel and writing a wiper directly take effect on the next edge and leave `ready` high.

An active-low preset pin overrides the command path. While it is held low, both wipers sit at midscale. When it is released, the saved settings are reloaded after a timed restore. A preset pulse that arrives during a long operation is remembered and handled when that operation ends.

Top module: `nvs_seq`

## Requirements
- R1: Word 0 saves channel 0 and word 1 saves channel 1. Both reset to midscale 0x200. User words 2..14 reset to 0x0000. Word 15 always reads TOL_WORD (default 0x0F1E).
- R2: While reset is asserted, and for LOADALL_CYC cycles after it is released, `ready` is low and `busy` is high. After that, both wipers hold the values of words 0 and 1.
- R3: Command codes on `cmd_op` are 0 none, 1 restore one channel, 2 save, 3 restore both, 4 read word and 5 write wiper. A command is taken only in a cycle where `cmd_valid` is high and `busy` is low. Any other command has no effect.
- R4: A save holds `ready` low for SAVE_CYC cycles and then writes the word at `cmd_addr`. For address 0 or 1 the written value is that channel's wiper, zero-extended. For addresses 2..14 it is `cmd_data`.
- R5: Restore-one loads the wiper chosen by `cmd_addr` (0 or 1) from its saved word on the next edge, and `ready` stays high. Restore-both holds `ready` low for LOADALL_CYC cycles and then loads both wipers.
- R6: A read holds `ready` low for FETCH_CYC cycles. `rd_data` takes the addressed word in the same edge that raises `ready` and changes at no other time.
- R7: Write-wiper loads `cmd_data[9:0]` into the wiper chosen by `cmd_addr` on the next edge, and `ready` stays high.
- R8: While `wp_n` is low, save and write-wiper commands have no effect and cause no ready pulse. Restore-one and restore-both still work.
- R9: A save to word 15 is ignored. The array is unchanged and `ready` stays high.
- R10: A falling edge on `preset_n` while idle forces both wipers to midscale on the next edge. While it stays low, `busy` is high, `ready` is high and the wipers stay at midscale. After it rises, `ready` is low for PRESET_CYC cycles and then both wipers load from words 0 and 1.
- R11: A `preset_n` falling edge during a timed operation is queued. When that operation ends, the wipers go to midscale and the preset restore of R10 follows.
- R12: Whenever `ready` is low, `busy` is high. The wipers do not change while `ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R3) |
| cmd_addr | input | 4 | Word address or channel select |
| cmd_data | input | 16 | User word or wiper value |
| preset_n | input | 1 | Active-low preset pin |
| wp_n | input | 1 | Active-low write protect |
| ready | output | 1 | High when no timed operation is running |
| busy | output | 1 | Front-end lock; high whenever commands are refused |
| wiper0 | output | 10 | Channel 0 wiper register |
| wiper1 | output | 10 | Channel 1 wiper register |
| rd_data | output | 16 | Last word read from the array |

## Verification
An error in the operation state or the shared latency counter shows up at once as a `ready` low interval of the wrong length. The bench counts that length cycle by cycle against each parameter. A bad array write, such as a wrong source word, a protected word being touched, or a write made while write protect is low, stays hidden until a later read or restore of that word. For that reason, every save in the bench is followed by a read or restore within a few commands. A lost or misrouted queued preset appears one edge after the long operation ends: the wipers are not at midscale and `busy` has already dropped.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_LOAD1   = 3'd1,
        OP_SAVE    = 3'd2,
        OP_LOADALL = 3'd3,
        OP_FETCH   = 3'd4,
        OP_SETW    = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SAVE,
        S_LOADALL,
        S_FETCH,
        S_HOLD,
        S_PLOAD
    } state_e;
endpackage

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int WORDS   = 16,
    parameter int WORD_W  = 16,
    parameter int WIPER_W = 10,
    parameter logic [WORD_W-1:0] TOL_WORD = 16'h0F1E,
    localparam int AW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata,
    output logic [WIPER_W-1:0] save0,
    output logic [WIPER_W-1:0] save1
);
    localparam logic [WORD_W-1:0] MID_WORD = WORD_W'(1) << (WIPER_W - 1);

    logic [WORD_W-1:0] mem [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam logic [WORD_W-1:0] RV =
            (i < 2) ? MID_WORD : ((i == WORDS - 1) ? TOL_WORD : '0);
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= RV;
            else if (we && waddr == AW'(i))
                mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];
    assign save0 = mem[0][WIPER_W-1:0];
    assign save1 = mem[1][WIPER_W-1:0];
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int CW      = 8,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CW'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nvs_edge.sv
module nvs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b1;
        else
            prev_q <= lvl_n;
    end

    assign fall = prev_q & ~lvl_n;
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int WORDS       = 16,
    parameter int WORD_W      = 16,
    parameter int WIPER_W     = 10,
    parameter int SAVE_CYC    = 60,
    parameter int LOADALL_CYC = 10,
    parameter int FETCH_CYC   = 4,
    parameter int PRESET_CYC  = 14,
    parameter logic [WORD_W-1:0] TOL_WORD = 16'h0F1E,
    localparam int AW = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [AW-1:0]      cmd_addr,
    input  logic [WORD_W-1:0]  cmd_data,
    input  logic               preset_n,
    input  logic               wp_n,
    output logic               ready,
    output logic               busy,
    output logic [WIPER_W-1:0] wiper0,
    output logic [WIPER_W-1:0] wiper1,
    output logic [WORD_W-1:0]  rd_data
);
    localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);
    localparam int TOP_ADDR = WORDS - 1;
    localparam int M1   = (SAVE_CYC > LOADALL_CYC) ? SAVE_CYC : LOADALL_CYC;
    localparam int M2   = (FETCH_CYC > PRESET_CYC) ? FETCH_CYC : PRESET_CYC;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        state_e             st;
        logic [WIPER_W-1:0] w0;
        logic [WIPER_W-1:0] w1;
        logic               rdy;
        logic               pend;
        logic [AW-1:0]      adr;
        logic [WORD_W-1:0]  dat;
        logic [WORD_W-1:0]  rd;
    } seq_t;

    seq_t s_q, s_d;

    logic               t_load, t_zero, p_fall;
    logic [CW-1:0]      t_val;
    logic               arr_we;
    logic [AW-1:0]      arr_waddr;
    logic [WORD_W-1:0]  arr_wdata, rword;
    logic [WIPER_W-1:0] save0, save1;

    nvs_array #(.WORDS(WORDS), .WORD_W(WORD_W), .WIPER_W(WIPER_W), .TOL_WORD(TOL_WORD)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(s_q.adr), .rdata(rword), .save0(save0), .save1(save1)
    );

    nvs_timer #(.CW(CW), .RST_VAL(LOADALL_CYC - 1)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    nvs_edge u_edge (.clk(clk), .rst_n(rst_n), .lvl_n(preset_n), .fall(p_fall));

    always_comb begin
        s_d       = s_q;
        t_load    = 1'b0;
        t_val     = '0;
        arr_we    = 1'b0;
        arr_waddr = s_q.adr;
        arr_wdata = s_q.dat;
        case (s_q.st)
            S_IDLE: begin
                if (p_fall) begin
                    s_d.st = S_HOLD;
                    s_d.w0 = MID;
                    s_d.w1 = MID;
                end else if (cmd_valid) begin
                    case (cmd_op)
                        OP_LOAD1: begin
                            if (cmd_addr == AW'(0)) s_d.w0 = save0;
                            else if (cmd_addr == AW'(1)) s_d.w1 = save1;
                        end
                        OP_SAVE: begin
                            if (wp_n && cmd_addr != AW'(TOP_ADDR)) begin
                                s_d.st  = S_SAVE;
                                s_d.rdy = 1'b0;
                                s_d.adr = cmd_addr;
                                s_d.dat = cmd_data;
                                t_load  = 1'b1;
                                t_val   = CW'(SAVE_CYC - 1);
                            end
                        end
                        OP_LOADALL: begin
                            s_d.st  = S_LOADALL;
                            s_d.rdy = 1'b0;
                            t_load  = 1'b1;
                            t_val   = CW'(LOADALL_CYC - 1);
                        end
                        OP_FETCH: begin
                            s_d.st  = S_FETCH;
                            s_d.rdy = 1'b0;
                            s_d.adr = cmd_addr;
                            t_load  = 1'b1;
                            t_val   = CW'(FETCH_CYC - 1);
                        end
                        OP_SETW: begin
                            if (wp_n) begin
                                if (cmd_addr == AW'(0)) s_d.w0 = cmd_data[WIPER_W-1:0];
                                else if (cmd_addr == AW'(1)) s_d.w1 = cmd_data[WIPER_W-1:0];
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_HOLD: begin
                s_d.w0 = MID;
                s_d.w1 = MID;
                if (preset_n) begin
                    s_d.st  = S_PLOAD;
                    s_d.rdy = 1'b0;
                    t_load  = 1'b1;
                    t_val   = CW'(PRESET_CYC - 1);
                end
            end
            default: begin
                s_d.pend = s_q.pend | p_fall;
                if (t_zero) begin
                    s_d.rdy  = 1'b1;
                    s_d.pend = 1'b0;
                    case (s_q.st)
                        S_SAVE: begin
                            arr_we = 1'b1;
                            if (s_q.adr == AW'(0))      arr_wdata = WORD_W'(s_q.w0);
                            else if (s_q.adr == AW'(1)) arr_wdata = WORD_W'(s_q.w1);
                        end
                        S_FETCH: s_d.rd = rword;
                        default: begin
                            s_d.w0 = save0;
                            s_d.w1 = save1;
                        end
                    endcase
                    if (s_q.pend || p_fall) begin
                        s_d.st = S_HOLD;
                        s_d.w0 = MID;
                        s_d.w1 = MID;
                    end else begin
                        s_d.st = S_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= S_LOADALL;
            s_q.w0   <= MID;
            s_q.w1   <= MID;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready   = s_q.rdy;
    assign busy    = (s_q.st != S_IDLE);
    assign wiper0  = s_q.w0;
    assign wiper1  = s_q.w1;
    assign rd_data = s_q.rd;
endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk #(
    parameter int WIPER_W  = 10,
    parameter int WORD_W   = 16,
    parameter int AW       = 4,
    parameter int TOP_ADDR = 15,
    parameter int MAXC     = 60
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               busy,
    input logic               wp_n,
    input logic               cmd_valid,
    input logic [2:0]         cmd_op,
    input logic [WIPER_W-1:0] wiper0,
    input logic [WIPER_W-1:0] wiper1,
    input logic [WORD_W-1:0]  rd_data,
    input logic               arr_we,
    input logic [AW-1:0]      arr_waddr
);
    localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

    logic [15:0] low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (!ready)
            low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1;
        else
            low_cnt <= '0;
    end

    AST_RDY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> busy); // R12
    AST_WIPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (ready || ($stable(wiper0) && $stable(wiper1)))); // R12
    AST_HOLD_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ready) |-> (wiper0 == MID && wiper1 == MID)); // R10
    AST_TOL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_waddr != AW'(TOP_ADDR))); // R9
    AST_RD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $rose(ready)); // R6
    AST_WP_NO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && cmd_valid && !busy && cmd_op == 3'd2) |=> ready); // R8
    AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= 16'(MAXC)); // R4
endmodule

bind nvs_seq nvs_seq_chk #(
    .WIPER_W(WIPER_W), .WORD_W(WORD_W), .AW(AW), .TOP_ADDR(TOP_ADDR), .MAXC(MAXC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .busy(busy), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wiper0(wiper0), .wiper1(wiper1),
    .rd_data(rd_data), .arr_we(arr_we), .arr_waddr(arr_waddr)
);

// File: tb/tb_nvs_seq.sv
module tb_nvs_seq;
    import nvs_pkg::*;

    localparam int SAVE_N = 60;
    localparam int ALL_N  = 10;
    localparam int RD_N   = 4;
    localparam int PR_N   = 14;
    localparam logic [15:0] TOL = 16'h0F1E;
    localparam logic [9:0]  MID = 10'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [3:0]  cmd_addr = 4'd0;
    logic [15:0] cmd_data = 16'd0;
    logic        preset_n = 1'b1;
    logic        wp_n = 1'b1;
    logic        ready, busy;
    logic [9:0]  wiper0, wiper1;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    nvs_seq #(.SAVE_CYC(SAVE_N), .LOADALL_CYC(ALL_N), .FETCH_CYC(RD_N),
              .PRESET_CYC(PR_N), .TOL_WORD(TOL)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .preset_n(preset_n), .wp_n(wp_n),
        .ready(ready), .busy(busy), .wiper0(wiper0), .wiper1(wiper1), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // count sampled cycles with ready low, starting at the current negedge
    task automatic count_low(output int n);
        n = 0;
        while (!ready && n < 5000) begin
            n = n + 1;
            @(negedge clk);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [3:0] a, input logic [15:0] dat,
                         input logic wp);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = dat; wp_n = wp;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  a;
        logic [15:0] dat;
        logic        wp;
        logic [7:0]  low;
        logic [1:0]  chk;   // 0 none, 1 wiper0, 2 wiper1, 3 rd_data
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{OP_FETCH,   4'd1,  16'h0000, 1'b1, 8'(RD_N),   2'd3, 16'h0200, 4'd1},  // R1
        '{OP_FETCH,   4'd2,  16'h0000, 1'b1, 8'(RD_N),   2'd3, 16'h0000, 4'd1},  // R1
        '{OP_FETCH,   4'd15, 16'h0000, 1'b1, 8'(RD_N),   2'd3, TOL,      4'd1},  // R1
        '{OP_SETW,    4'd0,  16'h0123, 1'b1, 8'd0,       2'd1, 16'h0123, 4'd7},  // R7
        '{OP_SAVE,    4'd0,  16'h0000, 1'b1, 8'(SAVE_N), 2'd1, 16'h0123, 4'd4},  // R4
        '{OP_FETCH,   4'd0,  16'h0000, 1'b1, 8'(RD_N),   2'd3, 16'h0123, 4'd4},  // R4
        '{OP_SETW,    4'd0,  16'h03FF, 1'b1, 8'd0,       2'd1, 16'h03FF, 4'd7},  // R7
        '{OP_LOAD1,   4'd0,  16'h0000, 1'b1, 8'd0,       2'd1, 16'h0123, 4'd5},  // R5
        '{OP_SETW,    4'd1,  16'h0055, 1'b1, 8'd0,       2'd2, 16'h0055, 4'd7},  // R7
        '{OP_SAVE,    4'd1,  16'h0000, 1'b1, 8'(SAVE_N), 2'd2, 16'h0055, 4'd4},  // R4
        '{OP_SETW,    4'd1,  16'h0000, 1'b1, 8'd0,       2'd2, 16'h0000, 4'd7},  // R7
        '{OP_LOADALL, 4'd0,  16'h0000, 1'b1, 8'(ALL_N),  2'd2, 16'h0055, 4'd5},  // R5
        '{OP_SAVE,    4'd5,  16'hBEEF, 1'b1, 8'(SAVE_N), 2'd0, 16'h0000, 4'd4},  // R4
        '{OP_FETCH,   4'd5,  16'h0000, 1'b1, 8'(RD_N),   2'd3, 16'hBEEF, 4'd4},  // R4
        '{OP_SAVE,    4'd15, 16'h1111, 1'b1, 8'd0,       2'd0, 16'h0000, 4'd9},  // R9
        '{OP_FETCH,   4'd15, 16'h0000, 1'b1, 8'(RD_N),   2'd3, TOL,      4'd9},  // R9
        '{OP_SETW,    4'd0,  16'h0200, 1'b0, 8'd0,       2'd1, 16'h0123, 4'd8},  // R8
        '{OP_SAVE,    4'd5,  16'h0000, 1'b0, 8'd0,       2'd0, 16'h0000, 4'd8},  // R8
        '{OP_FETCH,   4'd5,  16'h0000, 1'b0, 8'(RD_N),   2'd3, 16'hBEEF, 4'd8},  // R8
        '{OP_SETW,    4'd0,  16'h0001, 1'b1, 8'd0,       2'd1, 16'h0001, 4'd7},  // R7
        '{OP_LOAD1,   4'd0,  16'h0000, 1'b0, 8'd0,       2'd1, 16'h0123, 4'd8},  // R8
        '{OP_SETW,    4'd1,  16'h0003, 1'b1, 8'd0,       2'd2, 16'h0003, 4'd7},  // R7
        '{OP_LOADALL, 4'd0,  16'h0000, 1'b0, 8'(ALL_N),  2'd2, 16'h0055, 4'd8},  // R8
        '{OP_NONE,    4'd0,  16'h0000, 1'b1, 8'd0,       2'd1, 16'h0123, 4'd3}   // R3
    };

    initial begin
        int n;
        string tag;

        // R2: reset and automatic restore
        repeat (3) @(negedge clk);
        check("R2 ready in reset", 16'(ready), 16'h0);
        check("R2 busy in reset", 16'(busy), 16'h1);
        rst_n = 1'b1;
        count_low(n);
        check("R2 boot restore length", 16'(n), 16'(ALL_N));
        check("R2 wiper0 after boot", 16'(wiper0), 16'(MID));
        check("R2 wiper1 after boot", 16'(wiper1), 16'(MID));
        check("R2 busy after boot", 16'(busy), 16'h0);

        // table of commands
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].a, VECS[i].dat, VECS[i].wp);
            count_low(n);
            $sformat(tag, "R%0d vec%0d ready-low cycles", VECS[i].req, i);
            check(tag, 16'(n), 16'(VECS[i].low));
            $sformat(tag, "R%0d vec%0d result", VECS[i].req, i);
            case (VECS[i].chk)
                2'd1: check(tag, 16'(wiper0), VECS[i].exp);
                2'd2: check(tag, 16'(wiper1), VECS[i].exp);
                2'd3: check(tag, rd_data, VECS[i].exp);
                default: ;
            endcase
        end
        wp_n = 1'b1;

        // R3: commands offered while busy are dropped
        issue(OP_SAVE, 4'd6, 16'hAAAA, 1'b1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OP_SETW; cmd_addr = 4'd0; cmd_data = 16'h0011;
        @(negedge clk);
        cmd_op = OP_SAVE; cmd_addr = 4'd7; cmd_data = 16'h1234;
        @(negedge clk);
        cmd_valid = 1'b0;
        count_low(n);
        check("R3 wiper0 untouched while busy", 16'(wiper0), 16'h0123);
        issue(OP_FETCH, 4'd7, 16'h0, 1'b1);
        count_low(n);
        check("R3 word7 not saved while busy", rd_data, 16'h0000);
        issue(OP_FETCH, 4'd6, 16'h0, 1'b1);
        count_low(n);
        check("R4 word6 saved", rd_data, 16'hAAAA);

        // R10: preset hold and release
        @(negedge clk);
        preset_n = 1'b0;
        @(negedge clk);
        check("R10 wiper0 midscale on press", 16'(wiper0), 16'(MID));
        check("R10 wiper1 midscale on press", 16'(wiper1), 16'(MID));
        check("R10 ready high while held", 16'(ready), 16'h1);
        check("R10 busy while held", 16'(busy), 16'h1);
        repeat (6) @(negedge clk);
        check("R10 wiper0 still midscale", 16'(wiper0), 16'(MID));
        preset_n = 1'b1;
        @(negedge clk);
        count_low(n);
        check("R10 preset restore length", 16'(n), 16'(PR_N));
        check("R10 wiper0 restored", 16'(wiper0), 16'h0123);
        check("R10 wiper1 restored", 16'(wiper1), 16'h0055);

        // R11: preset pulse during a save is queued
        issue(OP_SETW, 4'd0, 16'h00AB, 1'b1);
        issue(OP_SAVE, 4'd0, 16'h0, 1'b1);
        repeat (5) @(negedge clk);
        preset_n = 1'b0;
        repeat (2) @(negedge clk);
        preset_n = 1'b1;
        check("R11 save still running", 16'(ready), 16'h0);
        count_low(n);
        check("R11 busy after save (preset queued)", 16'(busy), 16'h1);
        check("R11 wiper0 midscale after save", 16'(wiper0), 16'(MID));
        @(negedge clk);
        count_low(n);
        check("R11 queued preset restore length", 16'(n), 16'(PR_N));
        check("R11 wiper0 from new saved word", 16'(wiper0), 16'h00AB);
        check("R11 wiper1 restored", 16'(wiper1), 16'h0055);
        check("R12 idle after restore", 16'(busy), 16'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule